// File: doc/BRIEF.md
# SPI Shift-Mode Master Controller

This block is an SPI master driven through a small 32-bit register bus. Software first loads an outgoing word, then writes a command word. The command word carries a start bit, a chip-select choice, a frame-end flag and a bit count. The block then shifts up to 32 bits out on MOSI, most significant bit first, and takes up to 32 bits in from MISO. It uses SPI mode 0: SCLK idles low, MISO is sampled on the rising edge, and MOSI changes only while SCLK is low.

The start bit in the command register reads back as a busy flag. It clears by itself once the last bit has gone out, so software polls it to see when a chunk is done. A frame longer than 32 bits is built from several commands. Each command except the last leaves the frame-end flag clear, which keeps the chip-select line low between the separately triggered chunks. When no frame is held, the idle levels of the chip-select lines and of MOSI come from a pin-level register.

Register map (byte offsets): 0x00 enable, 0x04 clock divider, 0x08 pin levels, 0x10 transmit word, 0x14 command, 0x18 receive word. All other offsets read as zero.

Top module: `spi_shift_ctrl`

## Requirements
- R1: After reset: the pin-level register reads 0x0007_0000, the enable register reads 0, every spi_cs_n line is 1, and spi_sclk and spi_mosi are 0.
- R2: Reads return data in bus_rdata with bus_rvalid high one cycle after bus_rd. While enable bit 0 (offset 0x00) is 0, writes to every other offset are ignored and reads of every other offset return 0.
- R3: Command word layout: bit 31 starts a shift, bit 28+n selects chip select n (active low on spi_cs_n[n]), bit 26 is frame-end, and bits [5:0] give the bit count. A start with a count from 1 to 32 shifts exactly that many bits.
- R4: Bit 31 of the command register reads 1 while shifting. It clears at the clock edge 2*N*(D+1) cycles after the write edge, for N bits and divider D.
- R5: SCLK half-period is D+1 clock cycles, where D comes from divider register bits [5:0] (0 to 63). The first rising edge comes D+1 cycles after the write edge. Each command gives exactly N rising edges, and SCLK is low whenever no shift is in progress.
- R6: MOSI sends the low N bits of the transmit word, bit N-1 first and bit 0 last. MOSI does not change while SCLK is high.
- R7: MISO is sampled on each rising SCLK edge. After the shift, the receive word holds the N received bits in its low bits, with the last bit in bit 0, and zeros above them.
- R8: The selected chip-select lines stay low and steady for the whole shift. If frame-end is 1, they return to idle when the last bit completes. If frame-end is 0, they stay low until a later command with frame-end 1 completes.
- R9: When a line is not held by a frame, spi_cs_n[n] follows pin-level bit 16+n. When no shift is in progress, spi_mosi follows pin-level bit 0.
- R10: While a shift is in progress, writes to the transmit, divider, pin-level and command registers are ignored.
- R11: A command write with bit 31 clear has no effect: no shift starts and the command read-back does not change.
- R12: A start with a count of 0 or above 32 does not toggle SCLK and does not move chip select. The busy bit reads 0 straight away and the receive word is left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 5 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| bus_rvalid | output | 1 | Read data valid, one cycle after bus_rd |
| spi_sclk | output | 1 | Serial clock, idles low |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs_n | output | NUM_CS | Active-low chip selects |

## Verification
Some rules can be checked on every cycle, and the assertions cover those. SCLK stays low when idle. MOSI holds steady while SCLK is high. Chip select does not move during a shift. A frame-end command releases its lines on completion. The divider counter stays within range. A start never arrives while a shift is busy, and a transmit write during a shift leaves the stored word alone. Other behaviour can only be shown by running scenarios, and the bench does that. It measures bit order and receive packing across every divider, count and chip-select mix. It measures the exact edge timing and the busy-to-idle delay. It checks chip select held across chunks. It checks that writes made while busy, while disabled, or with start clear, and commands with an out-of-range count, change nothing.

// File: rtl/spi_shift_pkg.sv
package spi_shift_pkg;
  localparam int unsigned REG_W  = 32;
  localparam int unsigned ADDR_W = 5;

  localparam logic [ADDR_W-1:0] OFF_ENABLE = 5'h00;
  localparam logic [ADDR_W-1:0] OFF_CLKCFG = 5'h04;
  localparam logic [ADDR_W-1:0] OFF_PINCTL = 5'h08;
  localparam logic [ADDR_W-1:0] OFF_TXWORD = 5'h10;
  localparam logic [ADDR_W-1:0] OFF_CMD    = 5'h14;
  localparam logic [ADDR_W-1:0] OFF_RXWORD = 5'h18;

  localparam int unsigned CMD_GO_BIT   = 31;
  localparam int unsigned CMD_CS_LSB   = 28;
  localparam int unsigned CMD_TERM_BIT = 26;
  localparam int unsigned PIN_CS_LSB   = 16;
  localparam int unsigned PIN_MOSI_BIT = 0;

  typedef enum logic [1:0] {
    SH_IDLE = 2'd0,
    SH_LOW  = 2'd1,
    SH_HIGH = 2'd2
  } shift_state_e;
endpackage

// File: rtl/spi_shift_clkdiv.sv
module spi_shift_clkdiv #(
  parameter int unsigned DIV_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             restart,
  input  logic [DIV_W-1:0] div_val,
  output logic             half_tick
);
  logic [DIV_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || restart || !run) begin
      cnt_q <= '0;
    end else if (cnt_q == div_val) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + DIV_W'(1);
    end
  end

  assign half_tick = run && (cnt_q == div_val);

  // R5: the phase counter never passes the programmed divider while running
  assert_cnt_in_range_R5: assert property (@(posedge clk) disable iff (rst)
    run |-> (cnt_q <= div_val));
endmodule

// File: rtl/spi_shift_regs.sv
module spi_shift_regs
  import spi_shift_pkg::*;
#(
  parameter int unsigned NUM_CS = 3,
  parameter int unsigned DIV_W  = 6,
  parameter int unsigned CNT_W  = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  output logic              bus_rvalid,
  input  logic              busy,
  input  logic [REG_W-1:0]  rx_word,
  output logic [DIV_W-1:0]  div_val,
  output logic [NUM_CS-1:0] idle_cs,
  output logic              idle_mosi,
  output logic [REG_W-1:0]  tx_word,
  output logic              start,
  output logic [NUM_CS-1:0] cmd_cs,
  output logic              cmd_term,
  output logic [CNT_W-1:0]  cmd_count
);
  localparam logic [CNT_W:0] MAX_CNT = (CNT_W+1)'(REG_W);

  logic              enable_q;
  logic [NUM_CS-1:0] cs_q;
  logic              term_q;
  logic [CNT_W-1:0]  count_q;
  logic              wr_ok;
  logic              cmd_go;
  logic              count_ok;
  logic [REG_W-1:0]  cmd_word;
  logic [REG_W-1:0]  pin_word;
  logic [REG_W-1:0]  rd_mux;

  assign wr_ok     = bus_wr && enable_q && !busy;
  assign cmd_cs    = bus_wdata[CMD_CS_LSB +: NUM_CS];
  assign cmd_term  = bus_wdata[CMD_TERM_BIT];
  assign cmd_count = bus_wdata[CNT_W-1:0];
  assign cmd_go    = wr_ok && (bus_addr == OFF_CMD) && bus_wdata[CMD_GO_BIT];
  assign count_ok  = (cmd_count != '0) && ({1'b0, cmd_count} <= MAX_CNT);
  assign start     = cmd_go && count_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      enable_q  <= 1'b0;
      div_val   <= '0;
      idle_cs   <= '1;
      idle_mosi <= 1'b0;
      tx_word   <= '0;
      cs_q      <= '0;
      term_q    <= 1'b0;
      count_q   <= '0;
    end else begin
      if (bus_wr && (bus_addr == OFF_ENABLE)) begin
        enable_q <= bus_wdata[0];
      end
      if (wr_ok) begin
        case (bus_addr)
          OFF_CLKCFG: div_val <= bus_wdata[DIV_W-1:0];
          OFF_PINCTL: begin
            idle_cs   <= bus_wdata[PIN_CS_LSB +: NUM_CS];
            idle_mosi <= bus_wdata[PIN_MOSI_BIT];
          end
          OFF_TXWORD: tx_word <= bus_wdata;
          OFF_CMD: begin
            if (bus_wdata[CMD_GO_BIT]) begin
              cs_q    <= cmd_cs;
              term_q  <= cmd_term;
              count_q <= cmd_count;
            end
          end
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    cmd_word = '0;
    cmd_word[CMD_GO_BIT] = busy;
    cmd_word[CMD_CS_LSB +: NUM_CS] = cs_q;
    cmd_word[CMD_TERM_BIT] = term_q;
    cmd_word[CNT_W-1:0] = count_q;
    pin_word = '0;
    pin_word[PIN_CS_LSB +: NUM_CS] = idle_cs;
    pin_word[PIN_MOSI_BIT] = idle_mosi;
  end

  always_comb begin
    rd_mux = '0;
    if (bus_addr == OFF_ENABLE) begin
      rd_mux[0] = enable_q;
    end else if (enable_q) begin
      case (bus_addr)
        OFF_CLKCFG: rd_mux[DIV_W-1:0] = div_val;
        OFF_PINCTL: rd_mux = pin_word;
        OFF_TXWORD: rd_mux = tx_word;
        OFF_CMD:    rd_mux = cmd_word;
        OFF_RXWORD: rd_mux = rx_word;
        default:    rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= bus_rd;
      if (bus_rd) begin
        bus_rdata <= rd_mux;
      end
    end
  end

  // R10: a transmit-word write during a shift leaves the stored word unchanged
  assert_busy_tx_locked_R10: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && busy && (bus_addr == OFF_TXWORD)) |=> $stable(tx_word));

  // R2: with the block disabled, reads of any register but enable return zero
  assert_disabled_reads_zero_R2: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && !enable_q && (bus_addr != OFF_ENABLE)) |=> (bus_rdata == '0));
endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine
  import spi_shift_pkg::*;
#(
  parameter int unsigned NUM_CS = 3,
  parameter int unsigned CNT_W  = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [REG_W-1:0]  tx_word,
  input  logic [NUM_CS-1:0] cmd_cs,
  input  logic              cmd_term,
  input  logic [CNT_W-1:0]  cmd_count,
  input  logic              half_tick,
  input  logic              miso,
  input  logic [NUM_CS-1:0] idle_cs,
  input  logic              idle_mosi,
  output logic              busy,
  output logic              sclk,
  output logic              mosi,
  output logic [NUM_CS-1:0] cs_n,
  output logic [REG_W-1:0]  rx_word
);
  localparam int unsigned SH_W = $clog2(REG_W) + 1;

  shift_state_e      state_q;
  logic [REG_W-1:0]  shreg_q;
  logic [REG_W-1:0]  rx_q;
  logic [CNT_W-1:0]  left_q;
  logic [NUM_CS-1:0] hold_q;
  logic              term_q;
  logic              sclk_q;
  logic [SH_W-1:0]   pad;
  logic [REG_W-1:0]  aligned;

  // place bit N-1 of the transmit word at the top of the shift register
  assign pad     = SH_W'(REG_W) - SH_W'(cmd_count);
  assign aligned = tx_word << pad;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= SH_IDLE;
      shreg_q <= '0;
      rx_q    <= '0;
      left_q  <= '0;
      hold_q  <= '0;
      term_q  <= 1'b0;
      sclk_q  <= 1'b0;
    end else begin
      case (state_q)
        SH_IDLE: begin
          if (start) begin
            state_q <= SH_LOW;
            shreg_q <= aligned;
            rx_q    <= '0;
            left_q  <= cmd_count;
            hold_q  <= cmd_cs;
            term_q  <= cmd_term;
          end
        end
        SH_LOW: begin
          if (half_tick) begin
            sclk_q  <= 1'b1;
            rx_q    <= {rx_q[REG_W-2:0], miso};
            state_q <= SH_HIGH;
          end
        end
        SH_HIGH: begin
          if (half_tick) begin
            sclk_q <= 1'b0;
            left_q <= left_q - CNT_W'(1);
            if (left_q == CNT_W'(1)) begin
              state_q <= SH_IDLE;
              if (term_q) begin
                hold_q <= '0;
              end
            end else begin
              shreg_q <= {shreg_q[REG_W-2:0], 1'b0};
              state_q <= SH_LOW;
            end
          end
        end
        default: state_q <= SH_IDLE;
      endcase
    end
  end

  assign busy    = (state_q != SH_IDLE);
  assign sclk    = sclk_q;
  assign mosi    = busy ? shreg_q[REG_W-1] : idle_mosi;
  assign rx_word = rx_q;

  for (genvar n = 0; n < NUM_CS; n++) begin : g_cs
    assign cs_n[n] = hold_q[n] ? 1'b0 : idle_cs[n];
  end

  // R10: the register block only issues a start while the engine is idle
  assert_start_when_idle_R10: assert property (@(posedge clk) disable iff (rst)
    start |-> !busy);

  // R5: the serial clock rests low outside a shift
  assert_sclk_idle_low_R5: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !sclk);

  // R6: data out is steady through every high phase of the serial clock
  assert_mosi_steady_high_R6: assert property (@(posedge clk) disable iff (rst)
    sclk |-> $stable(mosi));

  // R8: chip selects do not move in the middle of a shift
  assert_cs_steady_busy_R8: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(cs_n));

  // R8: a frame-end command returns all lines to their idle levels on completion
  assert_cs_release_R8: assert property (@(posedge clk) disable iff (rst)
    ($fell(busy) && term_q) |-> (cs_n == idle_cs));

  // R4: a shift in progress always has bits left to move
  assert_bits_left_R4: assert property (@(posedge clk) disable iff (rst)
    busy |-> (left_q != '0));
endmodule

// File: rtl/spi_shift_ctrl.sv
module spi_shift_ctrl
  import spi_shift_pkg::*;
#(
  parameter int unsigned NUM_CS = 3,
  parameter int unsigned DIV_W  = 6,
  parameter int unsigned CNT_W  = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [4:0]        bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              bus_rvalid,
  output logic              spi_sclk,
  output logic              spi_mosi,
  input  logic              spi_miso,
  output logic [NUM_CS-1:0] spi_cs_n
);
  logic              busy;
  logic              start;
  logic              half_tick;
  logic [DIV_W-1:0]  div_val;
  logic [NUM_CS-1:0] idle_cs;
  logic              idle_mosi;
  logic [REG_W-1:0]  tx_word;
  logic [REG_W-1:0]  rx_word;
  logic [NUM_CS-1:0] cmd_cs;
  logic              cmd_term;
  logic [CNT_W-1:0]  cmd_count;

  spi_shift_regs #(
    .NUM_CS(NUM_CS), .DIV_W(DIV_W), .CNT_W(CNT_W)
  ) u_regs (
    .clk(clk), .rst(rst),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .busy(busy), .rx_word(rx_word),
    .div_val(div_val), .idle_cs(idle_cs), .idle_mosi(idle_mosi), .tx_word(tx_word),
    .start(start), .cmd_cs(cmd_cs), .cmd_term(cmd_term), .cmd_count(cmd_count)
  );

  spi_shift_clkdiv #(
    .DIV_W(DIV_W)
  ) u_clkdiv (
    .clk(clk), .rst(rst), .run(busy), .restart(start),
    .div_val(div_val), .half_tick(half_tick)
  );

  spi_shift_engine #(
    .NUM_CS(NUM_CS), .CNT_W(CNT_W)
  ) u_engine (
    .clk(clk), .rst(rst), .start(start), .tx_word(tx_word),
    .cmd_cs(cmd_cs), .cmd_term(cmd_term), .cmd_count(cmd_count),
    .half_tick(half_tick), .miso(spi_miso),
    .idle_cs(idle_cs), .idle_mosi(idle_mosi),
    .busy(busy), .sclk(spi_sclk), .mosi(spi_mosi), .cs_n(spi_cs_n), .rx_word(rx_word)
  );
endmodule

// File: tb/spi_shift_ctrl_test.sv
module spi_shift_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [4:0] A_EN = 5'h00, A_DIV = 5'h04, A_PIN = 5'h08,
                         A_TX = 5'h10, A_CMD = 5'h14, A_RX = 5'h18;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;
  logic        spi_sclk;
  logic        spi_mosi;
  logic        spi_miso;
  logic [2:0]  spi_cs_n;

  spi_shift_ctrl uut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_cs_n(spi_cs_n)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  always @(posedge clk) cyc = cyc + 1;

  // serial slave model
  int          nrise = 0;
  int          base_rise = 0;
  int          arm_rise = -1;
  int          xfer_n = 0;
  int          first_rise_cyc = 0;
  int          last_fall_cyc = 0;
  int          t0 = 0;
  logic [2:0]  cs_at_first = '1;
  logic [31:0] cap = '0;
  logic [31:0] miso_pat = '0;
  int          rel;

  always @(posedge spi_sclk) begin
    if (nrise == arm_rise) begin
      first_rise_cyc = cyc;
      cs_at_first = spi_cs_n;
    end
    cap = {cap[30:0], spi_mosi};
    nrise = nrise + 1;
  end
  always @(negedge spi_sclk) last_fall_cyc = cyc;

  assign rel = nrise - base_rise;
  assign spi_miso = (rel < xfer_n) ? miso_pat[xfer_n-1-rel] : 1'b0;

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  function automatic logic [31:0] low_mask(input int n);
    logic [63:0] m;
    m = (64'd1 << n) - 64'd1;
    return m[31:0];
  endfunction

  function automatic logic [31:0] cmd_val(input bit go, input int cs, input bit term, input int n);
    logic [31:0] v;
    v = 32'(n) & 32'h3F;
    v[31] = go;
    v[28+cs] = 1'b1;
    v[26] = term;
    return v;
  endfunction

  task automatic start_xfer(input int d, input int n, input int cs, input bit term,
                            input logic [31:0] tx, input logic [31:0] pat);
    logic [31:0] r;
    wr(A_DIV, 32'(d));
    wr(A_TX, tx);
    miso_pat = pat;
    xfer_n = n;
    base_rise = nrise;
    arm_rise = nrise;
    wr(A_CMD, cmd_val(1'b1, cs, term, n));
    t0 = cyc;
    rd(A_CMD, r);
    chk("R4", "busy bit right after start", {31'b0, r[31]}, 32'd1);
  endtask

  task automatic finish_xfer(input int d, input int n, input int cs, input bit term,
                             input logic [31:0] tx, input logic [31:0] pat);
    logic [31:0] r;
    logic [2:0]  sel;
    sel = 3'b111 & ~(3'b001 << cs);
    while (cyc < t0 + 2*n*(d+1) + 1) @(negedge clk);
    chk("R5", "rising edge count", 32'(nrise - base_rise), 32'(n));
    chk("R5", "first rise delay", 32'(first_rise_cyc - t0), 32'(d+1));
    chk("R4", "completion delay", 32'(last_fall_cyc - t0), 32'(2*n*(d+1)));
    chk("R6", "bits seen on mosi", cap & low_mask(n), tx & low_mask(n));
    chk("R3", "cs during shift", {29'b0, cs_at_first}, {29'b0, sel});
    chk("R8", "cs after completion", {29'b0, spi_cs_n}, {29'b0, term ? 3'b111 : sel});
    chk("R5", "sclk idle", {31'b0, spi_sclk}, 32'd0);
    rd(A_CMD, r);
    chk("R4", "busy bit after completion", {31'b0, r[31]}, 32'd0);
    rd(A_RX, r);
    chk("R7", "receive word", r, pat & low_mask(n));
  endtask

  initial begin
    logic [31:0] r;
    logic [31:0] tx;
    logic [31:0] pat;
    logic [31:0] cmd_before;
    int seed;
    int n0;

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    chk("R1", "cs_n after reset", {29'b0, spi_cs_n}, 32'h7);
    chk("R1", "sclk after reset", {31'b0, spi_sclk}, 32'd0);
    chk("R1", "mosi after reset", {31'b0, spi_mosi}, 32'd0);
    rd(A_EN, r);
    chk("R1", "enable after reset", r, 32'd0);
    chk("R2", "read valid strobe", {31'b0, bus_rvalid}, 32'd1);

    // R2 disabled block ignores writes and reads zero
    wr(A_TX, 32'h1234_5678);
    rd(A_TX, r);
    chk("R2", "read while disabled", r, 32'd0);
    wr(A_EN, 32'd1);
    rd(A_TX, r);
    chk("R2", "write while disabled ignored", r, 32'd0);
    rd(A_PIN, r);
    chk("R1", "pin-level reset value", r, 32'h0007_0000);

    // R9 idle pin levels
    wr(A_PIN, 32'h0005_0001);
    @(negedge clk);
    chk("R9", "idle cs from pin register", {29'b0, spi_cs_n}, 32'h5);
    chk("R9", "idle mosi from pin register", {31'b0, spi_mosi}, 32'd1);
    wr(A_PIN, 32'h0007_0000);
    @(negedge clk);
    chk("R9", "idle mosi restored", {31'b0, spi_mosi}, 32'd0);

    // main sweep: divider x count x chip select
    seed = 0;
    for (int di = 0; di < 3; di++) begin
      for (int ni = 1; ni <= 4; ni++) begin
        for (int c = 0; c < 3; c++) begin
          int d;
          d = (di == 2) ? 3 : di;
          seed++;
          tx  = 32'hC3A5_5A3C + 32'(seed) * 32'h0F1E_2D3B;
          pat = 32'h3C96_F00F ^ (32'(seed) * 32'h1357_9BDF);
          start_xfer(d, 8*ni, c, 1'b1, tx, pat);
          finish_xfer(d, 8*ni, c, 1'b1, tx, pat);
        end
      end
    end

    // odd counts and slowest divider
    start_xfer(0, 1, 2, 1'b1, 32'h0000_0001, 32'h0000_0001);
    finish_xfer(0, 1, 2, 1'b1, 32'h0000_0001, 32'h0000_0001);
    start_xfer(1, 5, 0, 1'b1, 32'hFFFF_FFF5, 32'h0000_000A);
    finish_xfer(1, 5, 0, 1'b1, 32'hFFFF_FFF5, 32'h0000_000A);
    start_xfer(63, 8, 1, 1'b1, 32'h0000_00B4, 32'h0000_004B);
    finish_xfer(63, 8, 1, 1'b1, 32'h0000_00B4, 32'h0000_004B);

    // R8 chip select held across chunks
    start_xfer(1, 8, 1, 1'b0, 32'h0000_00E7, 32'h0000_0019);
    finish_xfer(1, 8, 1, 1'b0, 32'h0000_00E7, 32'h0000_0019);
    repeat (5) @(negedge clk);
    chk("R8", "cs held between chunks", {29'b0, spi_cs_n}, 32'h5);
    start_xfer(1, 16, 1, 1'b1, 32'h0000_9C3A, 32'h0000_63C5);
    finish_xfer(1, 16, 1, 1'b1, 32'h0000_9C3A, 32'h0000_63C5);

    // R10 writes during a shift are ignored
    tx = 32'h8421_F00D;
    pat = 32'h5AA5_0FF0;
    start_xfer(3, 32, 0, 1'b1, tx, pat);
    wr(A_TX, ~tx);
    wr(A_DIV, 32'd7);
    wr(A_PIN, 32'h0000_0001);
    wr(A_CMD, cmd_val(1'b1, 2, 1'b1, 8));
    finish_xfer(3, 32, 0, 1'b1, tx, pat);
    repeat (40) @(negedge clk);
    chk("R10", "no second shift started", 32'(nrise - base_rise), 32'd32);
    rd(A_TX, r);
    chk("R10", "transmit word kept", r, tx);
    rd(A_DIV, r);
    chk("R10", "divider kept", r, 32'd3);
    rd(A_PIN, r);
    chk("R10", "pin levels kept", r, 32'h0007_0000);
    rd(A_CMD, r);
    chk("R10", "command read-back kept", r, cmd_val(1'b0, 0, 1'b1, 32));

    // R11 command with start clear
    rd(A_CMD, cmd_before);
    n0 = nrise;
    wr(A_CMD, cmd_val(1'b0, 1, 1'b0, 16));
    repeat (20) @(negedge clk);
    chk("R11", "no edges without start", 32'(nrise - n0), 32'd0);
    chk("R11", "cs untouched", {29'b0, spi_cs_n}, 32'h7);
    rd(A_CMD, r);
    chk("R11", "command read-back unchanged", r, cmd_before);

    // R12 out-of-range counts
    rd(A_RX, cmd_before);
    n0 = nrise;
    wr(A_CMD, cmd_val(1'b1, 0, 1'b0, 0));
    @(negedge clk);
    chk("R12", "cs unmoved for zero count", {29'b0, spi_cs_n}, 32'h7);
    rd(A_CMD, r);
    chk("R12", "busy clear for zero count", {31'b0, r[31]}, 32'd0);
    wr(A_CMD, cmd_val(1'b1, 2, 1'b1, 40));
    @(negedge clk);
    chk("R12", "cs unmoved for count 40", {29'b0, spi_cs_n}, 32'h7);
    rd(A_CMD, r);
    chk("R12", "busy clear for count 40", {31'b0, r[31]}, 32'd0);
    repeat (20) @(negedge clk);
    chk("R12", "no sclk edges", 32'(nrise - n0), 32'd0);
    rd(A_RX, r);
    chk("R12", "receive word unchanged", r, cmd_before);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL R4 watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule